// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects up to 32 device event lines into a sticky status vector and drives a single interrupt line toward a host processor. Each event line that is high on a clock edge sets its status bit, and the bit stays set until the host clears it. A per-bit mask decides which status bits may raise the interrupt. The mask resets with every bit set, so no interrupt reaches the host until software opens the bits it wants.

The host reaches the block through a single-cycle register port with word addresses. It can set or clear mask bits atomically with no read-modify-write. It can read the status in two ways: a peek view leaves the status unchanged, and a take view returns the status and clears it. It can also acknowledge individual bits by writing ones. A configuration word enables the interrupt pin and selects whether it is active-high or active-low. When the pin is disabled it rests at its inactive level.

The event inputs follow a conventional bit assignment:
- receive buffer data: bits 0 and 3
- transmit data: bit 1
- transmit transfer: bit 2
- receive transfer: bit 4
- mailbox events: bits 5 and 6
- wake: bit 7
- trace: bits 8 and 9
- command done: bit 10
- init done: bit 14
- coexistence sense on/off: bits 16 and 17

The block itself treats all bits the same.

Top module: `hint_status_ctrl`

## Requirements
- R1: An event line that is high on a clock edge sets its status bit at that edge. The bit then stays set while its event line is low and nothing clears it.
- R2: A write to address 1 (mask set) sets every mask bit whose written bit is 1 and leaves the mask bits written as 0 unchanged. The mask is read back at address 0.
- R3: A write to address 2 (mask clear) clears every mask bit whose written bit is 1 and leaves the mask bits written as 0 unchanged.
- R4: The pin is active one cycle after the pin is enabled while at least one status bit has its mask bit at 0. While every set status bit is masked, the pin is inactive.
- R5: A read of address 3 (peek) returns the status on bus_rdata_o in the cycle after the read strobe and does not change the status.
- R6: A read of address 4 (take) returns the status as it was before the read, then clears every status bit.
- R7: A write to address 5 (acknowledge) clears each status bit whose written bit is 1. Bits written as 0 have no effect.
- R8: An event that is high in the same cycle as a take read or an acknowledge of its bit wins: the bit stays set.
- R9: At address 6 (configuration), bit 5 enables the pin and bit 7 selects active-low. While bit 5 is 0, the pin rests at the level of bit 7. Both bits read back at their positions.
- R10: After reset the mask is all ones, the status and configuration are zero, and the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Event lines, one per status bit |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| host_irq_o | output | 1 | Host interrupt pin |

## Verification
Several properties are checked on every cycle:
- mask set and mask clear writes take effect bit by bit;
- a raised event line always leaves its status bit set, even against a clear;
- status bits never drop without a clear request;
- a take read with no incoming events empties the status;
- the pin tracks its enable and polarity.

Other behaviour only the bench scenarios can show:
- the value that a take read returns;
- a peek read leaving the status untouched;
- acknowledge with zero bits having no effect;
- the full interplay of mask, enable and polarity at the pin.

// File: rtl/hint_pkg.sv
package hint_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_MASK = 3'd0,
      A_MSET = 3'd1,
      A_MCLR = 3'd2,
      A_PEEK = 3'd3,
      A_TAKE = 3'd4,
      A_ACK  = 3'd5,
      A_CFG  = 3'd6,
      A_NONE = 3'd7
   } hint_addr_e;

   localparam int CFG_EN_BIT  = 5;
   localparam int CFG_LOW_BIT = 7;
endpackage

// File: rtl/hint_mask_bank.sv
module hint_mask_bank #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '1;
      else        mask_q <= (mask_q | set_vec) & ~clr_vec;
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec != '0) && (clr_vec == '0)) |=> ((mask_q & $past(set_vec)) == $past(set_vec))); // R2
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec != '0) && (set_vec == '0)) |=> ((mask_q & $past(clr_vec)) == '0)); // R3
   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec == '0) && (clr_vec == '0)) |=> $stable(mask_q)); // R2
endmodule

// File: rtl/hint_sticky_status.sv
module hint_sticky_status #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] status_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_vec) | evt;
   end

   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((status_q & $past(evt)) == $past(evt))); // R8
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec == '0) |=> ((status_q & $past(status_q)) == $past(status_q))); // R1
endmodule

// File: rtl/hint_pin_drive.sv
module hint_pin_drive #(
   parameter int N       = 32,
   parameter bit PIN_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status,
   input  logic [N-1:0] mask,
   input  logic         enable,
   input  logic         act_low,
   output logic         pin
);
   logic pending;
   logic level;

   assign pending = |(status & ~mask);
   assign level   = enable ? (pending ^ act_low) : act_low;

   generate
      if (PIN_REG) begin : g_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= level;
         end
         assign pin = pin_q;

         AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable) |=> (pin == $past(act_low))); // R9
         AST_PIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && ((status & ~mask) != '0)) |=> (pin != $past(act_low))); // R4
      end else begin : g_comb
         assign pin = level;
      end
   endgenerate
endmodule

// File: rtl/hint_status_ctrl.sv
module hint_status_ctrl #(
   parameter int NUM_EVT = 32,
   parameter int DATA_W  = 32,
   parameter bit PIN_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_EVT-1:0]         evt_i,
   input  logic                       bus_wr_i,
   input  logic                       bus_rd_i,
   input  logic [hint_pkg::ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0]          bus_wdata_i,
   output logic [DATA_W-1:0]          bus_rdata_o,
   output logic                       host_irq_o
);
   import hint_pkg::*;

   localparam int N = NUM_EVT;

   generate
      if (N < 1 || N > DATA_W) begin : g_bad_n
         $error("NUM_EVT must lie in 1..DATA_W");
      end
      if (DATA_W <= CFG_LOW_BIT) begin : g_bad_w
         $error("DATA_W too narrow for configuration bits");
      end
   endgenerate

   hint_addr_e   addr;
   logic [N-1:0] wvec;
   logic [N-1:0] mset_vec, mclr_vec, stat_clr;
   logic [N-1:0] mask_q, status_q;
   logic         cfg_en_q, cfg_low_q;
   logic         take_rd;
   logic [DATA_W-1:0] rd_mux;

   assign addr    = hint_addr_e'(bus_addr_i);
   assign wvec    = bus_wdata_i[N-1:0];
   assign take_rd = bus_rd_i && (addr == A_TAKE);

   always_comb begin
      mset_vec = '0;
      mclr_vec = '0;
      stat_clr = take_rd ? '1 : '0;
      if (bus_wr_i) begin
         case (addr)
            A_MSET:  mset_vec = wvec;
            A_MCLR:  mclr_vec = wvec;
            A_ACK:   stat_clr = stat_clr | wvec;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en_q  <= 1'b0;
         cfg_low_q <= 1'b0;
      end else if (bus_wr_i && addr == A_CFG) begin
         cfg_en_q  <= bus_wdata_i[CFG_EN_BIT];
         cfg_low_q <= bus_wdata_i[CFG_LOW_BIT];
      end
   end

   always_comb begin
      rd_mux = '0;
      case (addr)
         A_MASK: rd_mux[N-1:0] = mask_q;
         A_PEEK, A_TAKE: rd_mux[N-1:0] = status_q;
         A_CFG: begin
            rd_mux[CFG_EN_BIT]  = cfg_en_q;
            rd_mux[CFG_LOW_BIT] = cfg_low_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bus_rdata_o <= '0;
      else if (bus_rd_i) bus_rdata_o <= rd_mux;
   end

   hint_mask_bank #(.N(N)) mask_i (
      .clk(clk), .rst_n(rst_n), .set_vec(mset_vec), .clr_vec(mclr_vec), .mask_q(mask_q));

   hint_sticky_status #(.N(N)) stat_i (
      .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr_vec(stat_clr), .status_q(status_q));

   hint_pin_drive #(.N(N), .PIN_REG(PIN_REG)) pin_i (
      .clk(clk), .rst_n(rst_n), .status(status_q), .mask(mask_q),
      .enable(cfg_en_q), .act_low(cfg_low_q), .pin(host_irq_o));

   AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && addr == A_TAKE && evt_i == '0) |=> (status_q == '0)); // R6
   AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && addr == A_PEEK && !bus_wr_i && evt_i == '0) |=> $stable(status_q)); // R5
endmodule

// File: tb/hint_status_ctrl_tb_top.sv
module hint_status_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt_i = '0;
   logic        bus_wr_i = 1'b0;
   logic        bus_rd_i = 1'b0;
   logic [2:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        host_irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #10ns clk = ~clk;

   hint_status_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .host_irq_o(host_irq_o));

   // monitor: a read strobe seen at an edge means rdata is valid at the following negedge
   always @(posedge clk) rd_seen <= bus_rd_i;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: read with no expected entry, actual %h", bus_rdata_o);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata_o !== e) begin
               errors++;
               $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata_o, e);
            end
         end
      end
   end

   task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                      input logic [31:0] d, input logic [31:0] ev,
                      input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = d; evt_i = ev;
      if (rd) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      @(negedge clk);
      bus_wr_i = 1'b0; bus_rd_i = 1'b0; evt_i = '0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      cyc(1'b1, 1'b0, a, d, '0, '0, "");
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      cyc(1'b0, 1'b1, a, '0, '0, exp, tag);
   endtask

   task automatic pulse(input logic [31:0] ev);
      cyc(1'b0, 1'b0, 3'd7, '0, ev, '0, "");
   endtask

   task automatic pin_chk(input logic exp, input string tag);
      repeat (2) @(negedge clk);
      checks++;
      if (host_irq_o !== exp) begin
         errors++;
         $display("FAIL %s: pin actual %b expected %b", tag, host_irq_o, exp);
      end
   endtask

   initial begin
      #2ms;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      pin_chk(1'b0, "R10 pin");
      rd(3'd0, 32'hFFFF_FFFF, "R10 mask");
      rd(3'd3, 32'h0, "R10 status");
      rd(3'd6, 32'h0, "R10 cfg");
      // R1 capture and hold, R5 peek twice
      pulse(32'h0000_0402);
      repeat (3) @(negedge clk);
      rd(3'd3, 32'h0000_0402, "R1 sticky");
      rd(3'd3, 32'h0000_0402, "R5 peek unchanged");
      // R9 disabled, R4 fully masked
      pin_chk(1'b0, "R9 disabled");
      wr(3'd6, 32'h20);
      pin_chk(1'b0, "R4 masked");
      // R3 mask clear
      wr(3'd2, 32'h0000_0400);
      rd(3'd0, 32'hFFFF_FBFF, "R3 mask clear");
      pin_chk(1'b1, "R4 unmasked active");
      // R2 mask set
      wr(3'd1, 32'h0000_0401);
      rd(3'd0, 32'hFFFF_FFFF, "R2 mask set");
      pin_chk(1'b0, "R4 remasked");
      wr(3'd2, 32'h0000_0402);
      rd(3'd0, 32'hFFFF_FBFD, "R3 mask clear two bits");
      // R9 polarity
      wr(3'd6, 32'hA0);
      pin_chk(1'b0, "R9 active-low asserted");
      wr(3'd6, 32'h80);
      pin_chk(1'b1, "R9 disabled active-low rest");
      rd(3'd6, 32'h80, "R9 cfg readback");
      wr(3'd6, 32'hA0);
      // R7 acknowledge
      wr(3'd5, 32'h0000_0400);
      rd(3'd3, 32'h0000_0002, "R7 ack one bit");
      pin_chk(1'b0, "R4 still pending");
      wr(3'd5, 32'h0);
      rd(3'd3, 32'h0000_0002, "R7 ack zero no effect");
      // R6 take
      pulse(32'h0010_0008);
      rd(3'd4, 32'h0010_000A, "R6 take returns");
      rd(3'd3, 32'h0, "R6 take cleared");
      pin_chk(1'b1, "R6 pin idle after take");
      // R8 event vs take
      cyc(1'b0, 1'b1, 3'd4, '0, 32'h20, 32'h0, "R8 take with event");
      rd(3'd3, 32'h0000_0020, "R8 event survives take");
      // R8 event vs ack
      cyc(1'b1, 1'b0, 3'd5, 32'h20, 32'h20, '0, "");
      rd(3'd3, 32'h0000_0020, "R8 event survives ack");
      wr(3'd5, 32'h20);
      rd(3'd3, 32'h0, "R7 ack clears");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule